// File: doc/BRIEF.md
# Guard/Round/Sticky Mantissa Rounder

This block takes a mantissa that still holds two extra low-order positions (a guard bit and a round bit), together with a separate sticky bit and the sign of the value, and produces the mantissa rounded to its final width under one of four rounding modes. The two extra positions are dropped as part of the rounding step, so the result is always two bits narrower than the incoming mantissa.

It also reports whether any precision was lost (inexact) and whether an increment was applied (rounded up). Rounding up an all-ones mantissa ripples into one position above the top bit. That carry is passed on as its own output and is not normalized here, so the exponent logic downstream can detect a 2.0 result and adjust. The result is registered, and appears one clock after the inputs are presented.

Top module: `grs_round_unit`

## Requirements
- R1: While rst_n is low, and on the first clock edge after it goes low, every output is zero.
- R2: One clock after an input is presented, out_mant equals in_mant shifted right by two positions, plus one if an increment was applied, taken modulo 2^MANT_W.
- R3: When in_mant[1] (guard), in_mant[0] (round) and in_sticky are all zero, no increment is applied and out_inexact is 0, whatever the mode.
- R4: out_inexact is 1 exactly when at least one of guard, round or sticky is 1.
- R5: With in_mode = 2'b00 (nearest), there is no increment when guard is 0. With guard 1 and round or sticky 1, the value increments. With guard 1 and round and sticky both 0 (a tie), it increments only when bit 0 of the shifted mantissa (in_mant[2]) is 1.
- R6: With in_mode = 2'b01 (toward zero), no increment is ever applied.
- R7: With in_mode = 2'b10 (toward minus infinity), an inexact value increments only when in_sign is 1. With in_mode = 2'b11 (toward plus infinity), an inexact value increments only when in_sign is 0.
- R8: The increment propagates through every mantissa bit. out_carry is 1 exactly when an all-ones shifted mantissa was incremented, and out_mant is then all zeros.
- R9: out_rounded_up is 1 exactly when an increment was applied, so out_mant plus out_carry·2^MANT_W equals the shifted mantissa plus out_rounded_up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_mant | input | MANT_W+2 | Mantissa with guard (bit 1) and round (bit 0) positions |
| in_sticky | input | 1 | OR of all bits below the round position |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| out_mant | output | MANT_W | Rounded mantissa without guard and round bits |
| out_carry | output | 1 | Carry out of the top mantissa bit (2.0 result) |
| out_rounded_up | output | 1 | An increment was applied |
| out_inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
The hardest case to reach is the carry out of the top bit. It needs all MANT_W shifted bits to be one at the same moment as a mode, sign and guard pattern that calls for an increment, and uniform random mantissas almost never produce that. The bench therefore drives this case directly in each mode that can round up. It also puts a long all-ones prefix on part of the random stimulus. The nearest-mode tie, with guard set and round and sticky clear, is forced with both parities of in_mant[2]. That is the only place where the mantissa's own low bit changes the decision.

// File: rtl/grs_round_pkg.sv
package grs_round_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST  = 2'b00,
    RM_TO_ZERO  = 2'b01,
    RM_TO_NEG   = 2'b10,
    RM_TO_POS   = 2'b11
  } round_mode_e;

  // any discarded precision
  function automatic logic lost_bits(input logic g, input logic r, input logic s);
    return g | r | s;
  endfunction

  // nearest-even decision: needs guard, then either more below it or an odd lsb
  function automatic logic nearest_bump(input logic g, input logic r, input logic s,
                                        input logic lsb);
    return g & (r | s | lsb);
  endfunction

  // full increment decision for a given mode
  function automatic logic bump_for_mode(input round_mode_e mode, input logic g,
                                         input logic r, input logic s,
                                         input logic lsb, input logic neg);
    logic any;
    any = lost_bits(g, r, s);
    case (mode)
      RM_NEAREST: return nearest_bump(g, r, s, lsb);
      RM_TO_ZERO: return 1'b0;
      RM_TO_NEG:  return any & neg;
      RM_TO_POS:  return any & ~neg;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/grs_round_decide.sv
module grs_round_decide
  import grs_round_pkg::*;
(
  input  logic        guard_bit,
  input  logic        round_bit,
  input  logic        sticky_bit,
  input  logic        lsb_bit,
  input  logic        sign_bit,
  input  logic [1:0]  mode,
  output logic        bump,
  output logic        inexact
);

  round_mode_e mode_e;

  always_comb begin
    mode_e  = round_mode_e'(mode);
    inexact = lost_bits(guard_bit, round_bit, sticky_bit);
    bump    = bump_for_mode(mode_e, guard_bit, round_bit, sticky_bit, lsb_bit, sign_bit);
  end

endmodule

// File: rtl/grs_round_incr.sv
module grs_round_incr #(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] base,
  input  logic             bump,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  logic [WIDTH:0] chain;

  assign chain[0] = bump;

  // ripple of half adders, one per mantissa bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]     = base[i] ^ chain[i];
    assign chain[i+1] = base[i] & chain[i];
  end

  assign carry_out = chain[WIDTH];

endmodule

// File: rtl/grs_round_unit.sv
module grs_round_unit
  import grs_round_pkg::*;
#(
  parameter int MANT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W+1:0] in_mant,
  input  logic              in_sticky,
  input  logic              in_sign,
  input  logic [1:0]        in_mode,
  output logic [MANT_W-1:0] out_mant,
  output logic              out_carry,
  output logic              out_rounded_up,
  output logic              out_inexact
);

  localparam int GRS_DROP = 2;
  localparam int IN_W     = MANT_W + GRS_DROP;

  // named internal events for the assertions
  logic [MANT_W-1:0] shifted_w;
  logic [MANT_W-1:0] sum_w;
  logic              bump_w;
  logic              inexact_w;
  logic              carry_w;
  logic              guard_w;
  logic              round_w;

  assign shifted_w = in_mant[IN_W-1:GRS_DROP];
  assign guard_w   = in_mant[1];
  assign round_w   = in_mant[0];

  grs_round_decide u_decide (
    .guard_bit  (guard_w),
    .round_bit  (round_w),
    .sticky_bit (in_sticky),
    .lsb_bit    (shifted_w[0]),
    .sign_bit   (in_sign),
    .mode       (in_mode),
    .bump       (bump_w),
    .inexact    (inexact_w)
  );

  grs_round_incr #(.WIDTH(MANT_W)) u_incr (
    .base      (shifted_w),
    .bump      (bump_w),
    .sum       (sum_w),
    .carry_out (carry_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_mant       <= '0;
      out_carry      <= 1'b0;
      out_rounded_up <= 1'b0;
      out_inexact    <= 1'b0;
    end else begin
      out_mant       <= sum_w;
      out_carry      <= carry_w;
      out_rounded_up <= bump_w;
      out_inexact    <= inexact_w;
    end
  end

  // an increment never happens without lost precision
  assert_exact_no_bump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_rounded_up |-> out_inexact);

  assert_inexact_tracks_grs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_w | round_w | in_sticky) |=> out_inexact);

  assert_nearest_guard_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode == 2'b00 && !guard_w) |=> !out_rounded_up);

  assert_to_zero_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode == 2'b01) |=> !out_rounded_up);

  assert_directed_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_mode == 2'b10 && !in_sign) || (in_mode == 2'b11 && in_sign)) |=> !out_rounded_up);

  assert_carry_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_carry |-> (out_mant == '0 && out_rounded_up));

  assert_mant_holds_without_bump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bump_w |=> (out_mant == $past(shifted_w)));

endmodule

// File: tb/grs_round_unit_bench.sv
module grs_round_unit_bench;

  localparam int MW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [MW+1:0] in_mant = '0;
  logic          in_sticky = 1'b0;
  logic          in_sign = 1'b0;
  logic [1:0]    in_mode = 2'b00;
  logic [MW-1:0] out_mant;
  logic          out_carry;
  logic          out_rounded_up;
  logic          out_inexact;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  grs_round_unit #(.MANT_W(MW)) u_grs_round_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_mant        (in_mant),
    .in_sticky      (in_sticky),
    .in_sign        (in_sign),
    .in_mode        (in_mode),
    .out_mant       (out_mant),
    .out_carry      (out_carry),
    .out_rounded_up (out_rounded_up),
    .out_inexact    (out_inexact)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model written straight from the requirements
  task automatic apply(input logic [MW+1:0] m, input bit s, input bit sg, input int md);
    longint base, full;
    bit g, r, up, lost;
    string mtag;
    in_mant = m; in_sticky = s; in_sign = sg; in_mode = md[1:0];
    base = longint'(m) / 4;
    g = m[1]; r = m[0];
    lost = g || r || s;
    if (md == 0)      begin up = g && (r || s || (base % 2 == 1)); mtag = "R5"; end
    else if (md == 1) begin up = 0;                                mtag = "R6"; end
    else if (md == 2) begin up = lost && sg;                       mtag = "R7"; end
    else              begin up = lost && !sg;                      mtag = "R7"; end
    if (!lost) mtag = "R3";
    full = base + (up ? 1 : 0);
    @(negedge clk);
    check(mtag, out_rounded_up, up);
    check("R4", out_inexact, lost);
    check("R2", out_mant, full % (64'd1 << MW));
    check("R8", out_carry, full >> MW);
    check("R9", longint'(out_mant) + (longint'(out_carry) << MW), base + out_rounded_up);
  endtask

  initial begin
    logic [MW+1:0] ones;
    ones = '1;
    @(negedge clk);
    in_mant = '1; in_sticky = 1; in_mode = 2'b11;
    @(negedge clk); @(negedge clk);
    check("R1", {out_mant, out_carry, out_rounded_up, out_inexact}, 0);
    rst_n = 1'b1;
    // exact values in every mode
    for (int md = 0; md < 4; md++) begin
      apply({24'h123456, 2'b00}, 0, 0, md);
      apply({24'h654321, 2'b00}, 0, 1, md);
    end
    // nearest: guard low, above half, ties of both parities
    apply({24'h000010, 2'b01}, 1, 0, 0);
    apply({24'h000010, 2'b11}, 0, 0, 0);
    apply({24'h000010, 2'b10}, 1, 0, 0);
    apply({24'h000010, 2'b10}, 0, 0, 0);
    apply({24'h000011, 2'b10}, 0, 1, 0);
    // directed modes with both signs
    for (int md = 1; md < 4; md++) begin
      apply({24'h0000ff, 2'b01}, 0, 0, md);
      apply({24'h0000ff, 2'b00}, 1, 1, md);
    end
    // all-ones carry out (R8) in each mode that can round up
    apply(ones, 0, 0, 0);
    apply(ones, 0, 1, 2);
    apply(ones, 1, 0, 3);
    apply({ones[MW+1:2], 2'b10}, 0, 0, 0);
    apply({ones[MW+1:2], 2'b01}, 0, 0, 1);
    // random, half with long all-ones prefixes
    for (int i = 0; i < 3000; i++) begin
      logic [MW+1:0] m;
      m = MW'($urandom) << 2 | 2'($urandom);
      if (i % 2 == 1) m = m | (ones << ($urandom_range(2, 6)));
      apply(m, 1'($urandom), 1'($urandom), $urandom_range(0, 3));
    end
    // reset mid-stream returns outputs to zero
    in_mant = '1; in_sticky = 1; in_mode = 2'b00;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {out_mant, out_carry, out_rounded_up, out_inexact}, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule